// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block places a bank of 16-bit indirect words behind a handful of direct registers on a simple synchronous register bus. The host never addresses the indirect bank directly. It loads a direct data register and a direct index register instead. The order of those two writes sets the transfer direction. A data write followed by an index write stores the data word into the bank. An index write on its own fetches a word from the bank into the data register.

Transfers do not complete at once. A request stays pending until the next pulse on a slow periodic update strobe, which models a 16 kHz service rate as a single-cycle tick. A status bit reports the pending request. Each serviced transfer sets a sticky completion flag. The flag drives an interrupt output through an enable bit.

Direct register offsets on `regAddr`: 0 = data word, 1 = indirect index (low bits), 2 = transfer status (bit 0 = pending), 3 = completion flag (bit 0, write one to clear), 4 = interrupt enable (bit 0). All other offsets read as zero. The contents of the indirect bank are undefined after reset.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, reads of the data register, index register, status, completion flag and interrupt enable all return 0, and `irqOut` is 0.
- R2: A write to offset 0 followed by a write to offset 1 is a write request. At the next serviced tick, the data word is stored at the indirect index held at offset 1.
- R3: A write to offset 1 with no data write since the previous index write is a read request. At the next serviced tick, the indirect word at that index is copied into the data register at offset 0.
- R4: Status bit 0 at offset 2 reads 1 from the cycle after an index write until a tick services the request. It reads 0 afterwards. Without a tick, nothing is transferred.
- R5: An index write consumes the data-first marker. A later index write with no new data write is therefore a read, and it leaves the bank unchanged.
- R6: An index write that arrives while a request is pending replaces that request. Only the newest request is performed, at the next tick.
- R7: Each serviced transfer sets bit 0 at offset 3. The bit stays set until the host writes 1 to it; writing 0 has no effect. If a set and a clear fall in the same cycle, the set wins.
- R8: `irqOut` equals the completion flag ANDed with enable bit 0 at offset 4.
- R9: A read presents `regRdData` on the cycle after `regRdEn`. While a read request is pending, offset 0 returns the old data word; the new word is returned from the cycle after the servicing tick. Offset 1 returns the index zero-extended. Unmapped offsets return 0.
- R10: A tick with no pending request changes no register and does not set the completion flag.
- R11: A tick in the same cycle as an index write does not service the new request, which stays pending until the following tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Direct register offset |
| regWrEn | input | 1 | Single-cycle register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Registered read data |
| updTick | input | 1 | Single-cycle periodic update strobe |
| irqOut | output | 1 | Completion interrupt |

## Verification
A register write takes effect at the clock edge on which it is strobed, so every later read already sees it. Read data appears one edge after the read strobe. An indirect transfer lands on the edge that carries the update tick. The status, data and completion values it produces are therefore readable from the next cycle, and `irqOut` follows the completion flag with no extra register. The bench drives every strobe for exactly one cycle from the falling edge and samples each result on the following falling edge, so it observes the first cycle in which each value is due.

// File: rtl/ind_bridge_pkg.sv
package ind_bridge_pkg;
  localparam int BUS_AW = 3;

  localparam logic [BUS_AW-1:0] OFF_DATA  = 3'd0;
  localparam logic [BUS_AW-1:0] OFF_INDEX = 3'd1;
  localparam logic [BUS_AW-1:0] OFF_STAT  = 3'd2;
  localparam logic [BUS_AW-1:0] OFF_DONE  = 3'd3;
  localparam logic [BUS_AW-1:0] OFF_IEN   = 3'd4;

  typedef struct packed {
    logic loadData;   // host writes the data register
    logic loadIndex;  // host writes the index register
    logic bankWrite;  // serviced write transfer
    logic bankRead;   // serviced read transfer
  } ibrStrobes_t;
endpackage

// File: rtl/ibr_ctrl.sv
module ibr_ctrl
  import ind_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              clrBit,
  input  logic              enBit,
  input  logic              updTick,
  output ibrStrobes_t       strb,
  output logic              pending,
  output logic              doneFlag,
  output logic              irqEn
);
  logic dataFirst;
  logic pendWrite;
  logic service;
  logic wrDone;
  logic wrIen;

  always_comb begin
    strb.loadData  = regWrEn && (regAddr == OFF_DATA);
    strb.loadIndex = regWrEn && (regAddr == OFF_INDEX);
    wrDone         = regWrEn && (regAddr == OFF_DONE);
    wrIen          = regWrEn && (regAddr == OFF_IEN);
    service        = updTick && pending && !strb.loadIndex;
    strb.bankWrite = service && pendWrite;
    strb.bankRead  = service && !pendWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataFirst <= 1'b0;
      pendWrite <= 1'b0;
      pending   <= 1'b0;
      doneFlag  <= 1'b0;
      irqEn     <= 1'b0;
    end else begin
      if (strb.loadIndex) begin
        pending   <= 1'b1;
        pendWrite <= dataFirst;
        dataFirst <= 1'b0;
      end else begin
        if (strb.loadData) dataFirst <= 1'b1;
        if (service)       pending   <= 1'b0;
      end
      if (service)                doneFlag <= 1'b1;
      else if (wrDone && clrBit)  doneFlag <= 1'b0;
      if (wrIen) irqEn <= enBit;
    end
  end

  AST_PEND_ON_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadIndex |=> pending);  // R4
  AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (updTick && pending && !strb.loadIndex) |=> !pending);  // R4
  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !updTick) |=> pending);  // R4
  AST_SAME_CYCLE_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadIndex && updTick) |=> pending);  // R11
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bankWrite || strb.bankRead) |=> doneFlag);  // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !(wrDone && clrBit)) |=> doneFlag);  // R7
  AST_IDLE_TICK: assert property (@(posedge clk) disable iff (!rstN)
    (!pending && !doneFlag && !wrDone) |=> !doneFlag);  // R10
  AST_ONE_XFER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.bankWrite, strb.bankRead}));  // R6
endmodule

// File: rtl/ibr_datapath.sv
module ibr_datapath
  import ind_bridge_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int IAW  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ibrStrobes_t       strb,
  input  logic [BUS_AW-1:0] regAddr,
  input  logic              regRdEn,
  input  logic [DW-1:0]     regWrData,
  input  logic              pending,
  input  logic              doneFlag,
  input  logic              irqEn,
  output logic [DW-1:0]     regRdData
);
  logic [DW-1:0]  bank [DEPTH];
  logic [DW-1:0]  dataReg;
  logic [IAW-1:0] indexReg;
  logic [DW-1:0]  rdMux;

  always_ff @(posedge clk) begin
    if (strb.bankWrite) bank[indexReg] <= dataReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      indexReg <= '0;
    end else begin
      if (strb.loadData)      dataReg <= regWrData;
      else if (strb.bankRead) dataReg <= bank[indexReg];
      if (strb.loadIndex)     indexReg <= regWrData[IAW-1:0];
    end
  end

  always_comb begin
    unique case (regAddr)
      OFF_DATA:  rdMux = dataReg;
      OFF_INDEX: rdMux = {{(DW-IAW){1'b0}}, indexReg};
      OFF_STAT:  rdMux = {{(DW-1){1'b0}}, pending};
      OFF_DONE:  rdMux = {{(DW-1){1'b0}}, doneFlag};
      OFF_IEN:   rdMux = {{(DW-1){1'b0}}, irqEn};
      default:   rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)        regRdData <= '0;
    else if (regRdEn) regRdData <= rdMux;
  end

  AST_READ_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bankRead && !strb.loadData) |=> dataReg == $past(bank[indexReg]));  // R3
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    strb.bankWrite |=> bank[$past(indexReg)] == $past(dataReg));  // R2
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadData && !strb.bankRead) |=> $stable(dataReg));  // R9
endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ind_bridge_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DW-1:0]     regWrData,
  output logic [DW-1:0]     regRdData,
  input  logic              updTick,
  output logic              irqOut
);
  ibrStrobes_t strb;
  logic pending;
  logic doneFlag;
  logic irqEn;

  ibr_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .clrBit   (regWrData[0]),
    .enBit    (regWrData[0]),
    .updTick  (updTick),
    .strb     (strb),
    .pending  (pending),
    .doneFlag (doneFlag),
    .irqEn    (irqEn)
  );

  ibr_datapath #(.DW(DW), .DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regAddr   (regAddr),
    .regRdEn   (regRdEn),
    .regWrData (regWrData),
    .pending   (pending),
    .doneFlag  (doneFlag),
    .irqEn     (irqEn),
    .regRdData (regRdData)
  );

  assign irqOut = doneFlag && irqEn;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irqOut);  // R8
endmodule

// File: tb/tb_ind_reg_bridge.sv
`timescale 1ns/1ps
module tb_ind_reg_bridge;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        updTick = 1'b0;
  logic        irqOut;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ind_reg_bridge dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .updTick(updTick), .irqOut(irqOut)
  );

  // {index[4:0], data[15:0]}
  localparam int NV = 6;
  localparam logic [20:0] VEC [NV] = '{
    {5'd1,  16'hA5A5}, {5'd4,  16'h1234}, {5'd9,  16'hFFFF},
    {5'd12, 16'h0001}, {5'd20, 16'h8000}, {5'd31, 16'h7E3C}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    d = regRdData;
  endtask

  task automatic tick();
    @(negedge clk);
    updTick = 1'b1;
    @(negedge clk);
    updTick = 1'b0;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 irqOut", {15'd0, irqOut}, 16'd0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R1 reset reg", v, 16'd0);
    end

    // R2 table-driven indirect writes
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, VEC[i][15:0]);
      wr(3'd1, {11'd0, VEC[i][20:16]});
      tick();
      rd(3'd2, v); check("R4 pending cleared", v, 16'd0);
    end
    // R3 table-driven indirect reads (reverse order)
    for (int i = NV - 1; i >= 0; i--) begin
      wr(3'd1, {11'd0, VEC[i][20:16]});
      tick();
      rd(3'd0, v); check("R2/R3 readback", v, VEC[i][15:0]);
    end

    // R4/R9 pending bit and old data before tick
    wr(3'd0, 16'h5555);
    wr(3'd1, 16'd9);            // write request 0x5555 -> 9
    rd(3'd2, v); check("R4 pending set", v, 16'd1);
    repeat (4) @(negedge clk);
    rd(3'd2, v); check("R4 still pending", v, 16'd1);
    tick();
    wr(3'd1, 16'd12);           // read request
    rd(3'd0, v); check("R9 old data while pending", v, 16'h5555);
    tick();
    rd(3'd0, v); check("R9 new data after tick", v, 16'h0001);
    rd(3'd1, v); check("R9 index readback", v, 16'd12);
    rd(3'd6, v); check("R9 unmapped offset", v, 16'd0);

    // R5 marker consumed: second index write alone reads
    wr(3'd0, 16'hBEEF);
    wr(3'd1, 16'd20);
    tick();                      // 20 <- BEEF
    wr(3'd1, 16'd31);
    tick();
    rd(3'd0, v); check("R5 second index write reads", v, 16'h7E3C);
    wr(3'd1, 16'd31);
    tick();
    rd(3'd0, v); check("R5 bank unchanged", v, 16'h7E3C);

    // R6 replacement of a pending request
    wr(3'd0, 16'hDEAD);
    wr(3'd1, 16'd4);             // write request pending
    wr(3'd1, 16'd1);             // replaces with a read of 1
    tick();
    rd(3'd0, v); check("R6 replaced by read", v, 16'hA5A5);
    wr(3'd1, 16'd4);
    tick();
    rd(3'd0, v); check("R6 dropped write", v, 16'h1234);

    // R7 completion flag sticky, W1C
    rd(3'd3, v); check("R7 flag set", v, 16'd1);
    wr(3'd3, 16'd0);
    rd(3'd3, v); check("R7 write zero keeps", v, 16'd1);
    // R8 gating
    check("R8 irq disabled", {15'd0, irqOut}, 16'd0);
    wr(3'd4, 16'd1);
    check("R8 irq enabled", {15'd0, irqOut}, 16'd1);
    wr(3'd3, 16'd1);
    rd(3'd3, v); check("R7 cleared", v, 16'd0);
    check("R8 irq follows flag", {15'd0, irqOut}, 16'd0);

    // R10 idle tick
    tick();
    rd(3'd3, v); check("R10 no flag on idle tick", v, 16'd0);
    rd(3'd0, v); check("R10 data unchanged", v, 16'h1234);

    // R11 tick in same cycle as index write
    @(negedge clk);
    regAddr = 3'd1; regWrData = 16'd9; regWrEn = 1'b1; updTick = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; updTick = 1'b0;
    rd(3'd2, v); check("R11 still pending", v, 16'd1);
    rd(3'd3, v); check("R11 no completion", v, 16'd0);
    // R7 set wins over same-cycle clear
    @(negedge clk);
    regAddr = 3'd3; regWrData = 16'd1; regWrEn = 1'b1; updTick = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; updTick = 1'b0;
    rd(3'd3, v); check("R7 set beats clear", v, 16'd1);
    rd(3'd0, v); check("R11 serviced next tick", v, 16'h5555);
    check("R8 irq asserted", {15'd0, irqOut}, 16'd1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule